// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of line misses that a non-blocking data cache has sent to the next memory level and not yet received back. Each of a small number of slots holds the address of one memory line that is in flight. For every word of that line, the slot also holds the destination register of the load that wants that word. A load that misses is accepted on the miss port. If no slot holds its line, a free slot is claimed and one line request goes out in the same cycle. If a slot already waits for that line, the load joins it and no new request is sent. Either way the load leaves the pipeline and its destination register is flagged as empty.

An internal full/empty table covers every architectural register. The decode stage queries it and stalls any instruction whose source register is still empty. When the line comes back on the refill port, the slot writes each waiting word back to its register, one word per cycle. Each write-back flags that register full again. After the last waiting word the slot is freed. The cache data arrays are outside this block.

Top module: `mshr_file`

## Requirements
- R1: After reset no slot is in use. `miss_ready` is 1, `req_valid` and `wb_valid` are 0, and `sb_query_empty` is 0 for every register index.
- R2: A miss is accepted when no slot holds its line, a slot is free and the destination is not empty. In that same cycle `req_valid` is 1, `req_line_addr` equals `miss_line_addr` and `req_id` is the lowest-numbered free slot. No request is ever issued for that slot again.
- R3: A miss is merged when a slot holds its line, that slot has not yet been refilled and the word's destination field in it is unused. A merged miss is accepted (`miss_ready`=1) with `req_valid`=0. This holds even in the cycle that slot's refill arrives.
- R4: From the cycle after a miss is accepted, `sb_query_empty` is 1 for its `miss_dest` until that register is written back.
- R5: When every slot is in use and the miss's line is in none of them, `miss_ready` is 0.
- R6: When the slot holding the line already records a destination for `miss_word`, `miss_ready` is 0.
- R7: `miss_ready` is 0 in two further cases. One is when `miss_dest` is currently empty. The other is when the slot holding the line has already received its refill.
- R8: A refill (`rsp_valid` with `rsp_id`) loads the whole line into that slot. From the next cycle, `wb_valid` pulses once per cycle for each waiting word, in ascending word order. `wb_reg` is that word's destination and `wb_data` is word w of the line, taken from `rsp_line_data[w*DATA_W +: DATA_W]`.
- R9: Each write-back flags `wb_reg` full from the next cycle. The slot becomes free in the cycle after its last write-back and can then be allocated again.
- R10: When several refilled slots have words left, each cycle's write-back comes from the lowest-numbered such slot. Only one write-back happens per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load miss is offered |
| miss_ready | output | 1 | The offered miss can be taken this cycle |
| miss_line_addr | input | LINE_ADDR_W | Line address of the missing load |
| miss_word | input | log2(WORDS_PER_LINE) | Word within the line |
| miss_dest | input | REG_IDX_W | Destination register of the load |
| sb_query_reg | input | REG_IDX_W | Register index asked about by decode |
| sb_query_empty | output | 1 | 1 while the queried register awaits miss data |
| req_valid | output | 1 | One-cycle line request to the next level |
| req_id | output | log2(NUM_ENTRIES) | Slot that owns the request |
| req_line_addr | output | LINE_ADDR_W | Line address requested |
| rsp_valid | input | 1 | A refill line arrives |
| rsp_id | input | log2(NUM_ENTRIES) | Slot the refill belongs to |
| rsp_line_data | input | WORDS_PER_LINE*DATA_W | Whole line, word 0 in the low bits |
| wb_valid | output | 1 | A register write-back this cycle |
| wb_reg | output | REG_IDX_W | Register being written |
| wb_data | output | DATA_W | Value written |

## Verification
The bench targets a second load to a line that is already waiting. If the design issued a second request for it, `req_valid` would rise where it should stay low. If it lost the merge, a register would stay empty for good. The bench also drives a merge in the same cycle as that slot's refill, and a miss to a line whose refill has already arrived. It covers a word whose destination field is taken and a load that targets a register already empty. A wrong design would accept these loads and overwrite a waiting destination, or it would write one register twice. Last, two slots are refilled one cycle apart. If slot priority or word order were wrong, the write-back sequence would come out permuted, and if a slot were freed too early or too late, its reuse index would be wrong.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
   typedef enum logic [1:0] {
      SLOT_IDLE  = 2'd0,
      SLOT_WAIT  = 2'd1,
      SLOT_DRAIN = 2'd2
   } mshr_state_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry
   import mshr_pkg::*;
#(
   parameter int LINE_W = 26,
   parameter int WORDS  = 4,
   parameter int REG_W  = 5,
   parameter int DATA_W = 32,
   localparam int WORD_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc_i,
   input  logic                    merge_i,
   input  logic [WORD_W-1:0]       word_i,
   input  logic [REG_W-1:0]        dest_i,
   input  logic [LINE_W-1:0]       line_i,
   input  logic                    fill_i,
   input  logic [WORDS*DATA_W-1:0] fill_data_i,
   input  logic                    drain_i,
   input  logic [WORDS-1:0]        drain_clr_i,
   output logic                    busy_o,
   output logic                    draining_o,
   output logic [LINE_W-1:0]       line_o,
   output logic [WORDS-1:0]        vld_o,
   output logic [WORDS*REG_W-1:0]  dest_o,
   output logic [WORDS*DATA_W-1:0] data_o
);
   mshr_state_e              state_q;
   logic [LINE_W-1:0]        line_q;
   logic [WORDS-1:0]         vld_q, vld_d;
   logic [WORDS*REG_W-1:0]   dest_q;
   logic [WORDS*DATA_W-1:0]  data_q;
   logic                     wr_en, last_word;

   assign wr_en     = alloc_i | merge_i;
   assign last_word = drain_i && ((vld_q & ~drain_clr_i) == '0);

   always_comb begin
      vld_d = vld_q;
      if (drain_i) vld_d = vld_d & ~drain_clr_i;
      if (wr_en)   vld_d[word_i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SLOT_IDLE;
         line_q  <= '0;
         vld_q   <= '0;
         dest_q  <= '0;
         data_q  <= '0;
      end else begin
         vld_q <= vld_d;
         if (alloc_i) begin
            state_q <= SLOT_WAIT;
            line_q  <= line_i;
         end
         if (fill_i) begin
            state_q <= SLOT_DRAIN;
            data_q  <= fill_data_i;
         end
         if (last_word) state_q <= SLOT_IDLE;
         for (int i = 0; i < WORDS; i++) begin
            if (wr_en && word_i == WORD_W'(i))
               dest_q[i*REG_W +: REG_W] <= dest_i;
         end
      end
   end

   assign busy_o     = (state_q != SLOT_IDLE);
   assign draining_o = (state_q == SLOT_DRAIN);
   assign line_o     = line_q;
   assign vld_o      = vld_q;
   assign dest_o     = dest_q;
   assign data_o     = data_q;

   // R2: a slot is only claimed while it is free
   p_alloc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> (state_q == SLOT_IDLE && vld_q == '0));
   // R8: a refill only lands on a slot still waiting for it
   p_fill_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_i |-> (state_q == SLOT_WAIT));
   // R6: a merge never overwrites a waiting destination
   p_merge_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      merge_i |-> (state_q == SLOT_WAIT && !vld_q[word_i]));
endmodule

// File: rtl/mshr_drain_sel.sv
module mshr_drain_sel #(
   parameter int N     = 4,
   parameter int WORDS = 4,
   localparam int ENT_W  = (N > 1) ? $clog2(N) : 1,
   localparam int WORD_W = $clog2(WORDS)
) (
   input  logic [N-1:0]       draining_i,
   input  logic [N*WORDS-1:0] vld_flat_i,
   output logic               sel_valid_o,
   output logic [ENT_W-1:0]   sel_ent_o,
   output logic [WORD_W-1:0]  sel_word_o,
   output logic [WORDS-1:0]   sel_mask_o
);
   always_comb begin
      sel_valid_o = 1'b0;
      sel_ent_o   = '0;
      for (int e = 0; e < N; e++) begin
         if (!sel_valid_o && draining_i[e]) begin
            sel_valid_o = 1'b1;
            sel_ent_o   = ENT_W'(e);
         end
      end
      sel_word_o = '0;
      for (int w = WORDS - 1; w >= 0; w--) begin
         if (vld_flat_i[int'(sel_ent_o) * WORDS + w]) sel_word_o = WORD_W'(w);
      end
      sel_mask_o = '0;
      sel_mask_o[sel_word_o] = sel_valid_o;
   end
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
   parameter int REG_W = 5,
   localparam int NREG = 1 << REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en_i,
   input  logic [REG_W-1:0] set_idx_i,
   input  logic             clr_en_i,
   input  logic [REG_W-1:0] clr_idx_i,
   input  logic [REG_W-1:0] query_idx_i,
   output logic             query_empty_o,
   input  logic [REG_W-1:0] chk_idx_i,
   output logic             chk_empty_o
);
   logic [NREG-1:0] empty_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_q <= '0;
      end else begin
         if (clr_en_i) empty_q[clr_idx_i] <= 1'b0;
         if (set_en_i) empty_q[set_idx_i] <= 1'b1;
      end
   end

   assign query_empty_o = empty_q[query_idx_i];
   assign chk_empty_o   = empty_q[chk_idx_i];

   // R7: a register that is already waiting is never claimed again
   p_set_full_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_en_i |-> !empty_q[set_idx_i]);
   // R9: a write-back always targets a waiting register
   p_clr_empty_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en_i |-> empty_q[clr_idx_i]);
endmodule

// File: rtl/mshr_file.sv
module mshr_file
   import mshr_pkg::*;
#(
   parameter int NUM_ENTRIES    = 4,
   parameter int WORDS_PER_LINE = 4,
   parameter int LINE_ADDR_W    = 26,
   parameter int REG_IDX_W      = 5,
   parameter int DATA_W         = 32,
   localparam int ENT_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
   localparam int WORD_W = $clog2(WORDS_PER_LINE)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             miss_valid,
   output logic                             miss_ready,
   input  logic [LINE_ADDR_W-1:0]           miss_line_addr,
   input  logic [WORD_W-1:0]                miss_word,
   input  logic [REG_IDX_W-1:0]             miss_dest,
   input  logic [REG_IDX_W-1:0]             sb_query_reg,
   output logic                             sb_query_empty,
   output logic                             req_valid,
   output logic [ENT_W-1:0]                 req_id,
   output logic [LINE_ADDR_W-1:0]           req_line_addr,
   input  logic                             rsp_valid,
   input  logic [ENT_W-1:0]                 rsp_id,
   input  logic [WORDS_PER_LINE*DATA_W-1:0] rsp_line_data,
   output logic                             wb_valid,
   output logic [REG_IDX_W-1:0]             wb_reg,
   output logic [DATA_W-1:0]                wb_data
);
   localparam int WORDS = WORDS_PER_LINE;

   if (NUM_ENTRIES < 1 || WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_cfg
      $error("mshr_file: need NUM_ENTRIES >= 1 and a power-of-two WORDS_PER_LINE >= 2");
   end

   logic [NUM_ENTRIES-1:0]  busy, draining, hit_vec, alloc, merge, fill, drain;
   logic [LINE_ADDR_W-1:0]  line_arr [NUM_ENTRIES];
   logic [WORDS-1:0]        vld_arr  [NUM_ENTRIES];
   logic [WORDS*REG_IDX_W-1:0] dest_arr [NUM_ENTRIES];
   logic [WORDS*DATA_W-1:0] data_arr [NUM_ENTRIES];
   logic [NUM_ENTRIES*WORDS-1:0] vld_flat;

   logic             hit_any, free_any, dest_empty, accept;
   logic [ENT_W-1:0] hit_idx, free_idx, sel_ent;
   logic             sel_valid;
   logic [WORD_W-1:0] sel_word;
   logic [WORDS-1:0] sel_mask;

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      assign hit_vec[g] = busy[g] && (line_arr[g] == miss_line_addr);
      assign alloc[g]   = accept && !hit_any && (free_idx == ENT_W'(g));
      assign merge[g]   = accept &&  hit_any && (hit_idx  == ENT_W'(g));
      assign fill[g]    = rsp_valid && (rsp_id == ENT_W'(g));
      assign drain[g]   = sel_valid && (sel_ent == ENT_W'(g));
      assign vld_flat[g*WORDS +: WORDS] = vld_arr[g];

      mshr_entry #(
         .LINE_W(LINE_ADDR_W), .WORDS(WORDS), .REG_W(REG_IDX_W), .DATA_W(DATA_W)
      ) i_entry (
         .clk(clk), .rst_n(rst_n),
         .alloc_i(alloc[g]), .merge_i(merge[g]),
         .word_i(miss_word), .dest_i(miss_dest), .line_i(miss_line_addr),
         .fill_i(fill[g]), .fill_data_i(rsp_line_data),
         .drain_i(drain[g]), .drain_clr_i(sel_mask),
         .busy_o(busy[g]), .draining_o(draining[g]), .line_o(line_arr[g]),
         .vld_o(vld_arr[g]), .dest_o(dest_arr[g]), .data_o(data_arr[g])
      );
   end

   always_comb begin
      hit_any  = 1'b0;
      hit_idx  = '0;
      free_any = 1'b0;
      free_idx = '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         if (hit_vec[e]) begin
            hit_any = 1'b1;
            hit_idx = ENT_W'(e);
         end
         if (!free_any && !busy[e]) begin
            free_any = 1'b1;
            free_idx = ENT_W'(e);
         end
      end
   end

   assign miss_ready = !dest_empty &&
                       (hit_any ? (!draining[hit_idx] && !vld_arr[hit_idx][miss_word])
                                : free_any);
   assign accept     = miss_valid && miss_ready;

   assign req_valid     = accept && !hit_any;
   assign req_id        = free_idx;
   assign req_line_addr = miss_line_addr;

   mshr_drain_sel #(.N(NUM_ENTRIES), .WORDS(WORDS)) i_drain_sel (
      .draining_i(draining), .vld_flat_i(vld_flat),
      .sel_valid_o(sel_valid), .sel_ent_o(sel_ent),
      .sel_word_o(sel_word), .sel_mask_o(sel_mask)
   );

   assign wb_valid = sel_valid;
   assign wb_reg   = dest_arr[sel_ent][int'(sel_word)*REG_IDX_W +: REG_IDX_W];
   assign wb_data  = data_arr[sel_ent][int'(sel_word)*DATA_W +: DATA_W];

   mshr_scoreboard #(.REG_W(REG_IDX_W)) i_scoreboard (
      .clk(clk), .rst_n(rst_n),
      .set_en_i(accept), .set_idx_i(miss_dest),
      .clr_en_i(wb_valid), .clr_idx_i(wb_reg),
      .query_idx_i(sb_query_reg), .query_empty_o(sb_query_empty),
      .chk_idx_i(miss_dest), .chk_empty_o(dest_empty)
   );

   // R3: no two slots ever hold the same line
   p_single_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   // R10: the write-back always comes from a slot that holds a waiting word
   p_wb_from_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (draining[sel_ent] && vld_arr[sel_ent][sel_word]));
endmodule

// File: tb/test_mshr_file.sv
module test_mshr_file;
   localparam int N = 4, W = 4, LW = 26, RW = 5, DW = 32, EW = 2, WW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic            miss_valid = 1'b0;
   logic            miss_ready;
   logic [LW-1:0]   miss_line_addr = '0;
   logic [WW-1:0]   miss_word = '0;
   logic [RW-1:0]   miss_dest = '0;
   logic [RW-1:0]   sb_query_reg = '0;
   logic            sb_query_empty;
   logic            req_valid;
   logic [EW-1:0]   req_id;
   logic [LW-1:0]   req_line_addr;
   logic            rsp_valid = 1'b0;
   logic [EW-1:0]   rsp_id = '0;
   logic [W*DW-1:0] rsp_line_data = '0;
   logic            wb_valid;
   logic [RW-1:0]   wb_reg;
   logic [DW-1:0]   wb_data;

   mshr_file i_mshr_file (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_ready(miss_ready),
      .miss_line_addr(miss_line_addr), .miss_word(miss_word), .miss_dest(miss_dest),
      .sb_query_reg(sb_query_reg), .sb_query_empty(sb_query_empty),
      .req_valid(req_valid), .req_id(req_id), .req_line_addr(req_line_addr),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_line_data(rsp_line_data),
      .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int n_cyc   = 0;

   // reference model state
   bit            m_busy [N];
   bit            m_drain[N];
   logic [LW-1:0] m_line [N];
   bit            m_v    [N][W];
   logic [RW-1:0] m_d    [N][W];
   logic [DW-1:0] m_data [N][W];
   bit            m_empty[32];

   // per-cycle expectations
   bit    e_ready, e_req, e_hit, e_wb;
   int    e_hidx, e_fidx, e_went, e_wword, e_ndrain;
   string e_rtag;

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_comb();
      e_hit = 0; e_hidx = 0; e_fidx = -1;
      for (int e = 0; e < N; e++) begin
         if (m_busy[e] && m_line[e] == miss_line_addr) begin e_hit = 1; e_hidx = e; end
         if (!m_busy[e] && e_fidx < 0) e_fidx = e;
      end
      if (m_empty[miss_dest])         begin e_ready = 0; e_rtag = "R7"; end
      else if (e_hit) begin
         if (m_drain[e_hidx])                  begin e_ready = 0; e_rtag = "R7"; end
         else if (m_v[e_hidx][miss_word])      begin e_ready = 0; e_rtag = "R6"; end
         else                                  begin e_ready = 1; e_rtag = "R3"; end
      end
      else if (e_fidx < 0)            begin e_ready = 0; e_rtag = "R5"; end
      else                            begin e_ready = 1; e_rtag = "R2"; end
      e_req = miss_valid && e_ready && !e_hit;
      e_wb = 0; e_went = 0; e_wword = 0; e_ndrain = 0;
      for (int e = 0; e < N; e++) begin
         if (m_drain[e]) begin
            e_ndrain++;
            if (!e_wb) begin
               e_wb = 1; e_went = e;
               for (int w = W - 1; w >= 0; w--) if (m_v[e][w]) e_wword = w;
            end
         end
      end
   endtask

   task automatic compare();
      string wtag;
      wtag = (e_ndrain > 1) ? "R10" : "R8";
      check(e_rtag, "miss_ready", miss_ready, e_ready);
      check("R2", "req_valid", req_valid, e_req);
      if (e_req) begin
         check("R2", "req_id", req_id, e_fidx);
         check("R2", "req_line_addr", req_line_addr, miss_line_addr);
      end
      check(wtag, "wb_valid", wb_valid, e_wb);
      if (e_wb) begin
         check(wtag, "wb_reg", wb_reg, m_d[e_went][e_wword]);
         check(wtag, "wb_data", wb_data, m_data[e_went][e_wword]);
      end
      check("R4", "sb_query_empty", sb_query_empty, m_empty[sb_query_reg]);
   endtask

   task automatic model_seq();
      if (e_wb) begin
         bit any;
         m_v[e_went][e_wword] = 0;
         m_empty[m_d[e_went][e_wword]] = 0;
         any = 0;
         for (int w = 0; w < W; w++) any |= m_v[e_went][w];
         if (!any) begin m_busy[e_went] = 0; m_drain[e_went] = 0; end
      end
      if (miss_valid && e_ready) begin
         int t;
         t = e_hit ? e_hidx : e_fidx;
         if (!e_hit) begin m_busy[t] = 1; m_line[t] = miss_line_addr; end
         m_v[t][miss_word] = 1;
         m_d[t][miss_word] = miss_dest;
         m_empty[miss_dest] = 1;
      end
      if (rsp_valid) begin
         m_drain[rsp_id] = 1;
         for (int w = 0; w < W; w++) m_data[rsp_id][w] = rsp_line_data[w*DW +: DW];
      end
   endtask

   task automatic cyc();
      sb_query_reg = RW'(n_cyc);
      n_cyc++;
      #1;
      model_comb();
      compare();
      @(posedge clk);
      #1;
      model_seq();
      @(negedge clk);
   endtask

   task automatic drive(bit mv, logic [LW-1:0] la, int wd, int dst, bit rv, int rid);
      miss_valid = mv; miss_line_addr = la; miss_word = WW'(wd); miss_dest = RW'(dst);
      rsp_valid = rv; rsp_id = EW'(rid);
      for (int w = 0; w < W; w++) rsp_line_data[w*DW +: DW] = $urandom;
      cyc();
      miss_valid = 0; rsp_valid = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(0, '0, 0, 0, 0, 0);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int e = 0; e < N; e++) begin
         m_busy[e] = 0; m_drain[e] = 0; m_line[e] = '0;
         for (int w = 0; w < W; w++) begin m_v[e][w] = 0; m_d[e][w] = '0; m_data[e][w] = '0; end
      end
      for (int r = 0; r < 32; r++) m_empty[r] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1", "miss_ready", miss_ready, 1);
      check("R1", "req_valid", req_valid, 0);
      check("R1", "wb_valid", wb_valid, 0);
      for (int r = 0; r < 32; r++) begin
         sb_query_reg = RW'(r);
         #0.1;
         check("R1", "sb_query_empty", sb_query_empty, 0);
      end
      @(negedge clk);

      drive(1, 26'h100, 1, 3, 0, 0);   // R2 new line -> slot 0
      drive(1, 26'h100, 2, 4, 0, 0);   // R3 merge
      drive(1, 26'h100, 1, 5, 0, 0);   // R6 word taken
      drive(1, 26'h222, 0, 3, 0, 0);   // R7 dest already empty
      drive(1, 26'h200, 0, 6, 0, 0);   // slot 1
      drive(1, 26'h300, 3, 7, 0, 0);   // slot 2
      drive(1, 26'h400, 2, 8, 0, 0);   // slot 3
      drive(1, 26'h500, 0, 10, 0, 0);  // R5 all busy
      drive(1, 26'h300, 0, 9, 0, 0);   // merge into slot 2
      drive(1, 26'h300, 1, 11, 1, 2);  // merge in refill cycle
      drive(1, 26'h300, 2, 12, 1, 0);  // R7 refilled line; slot 0 refill -> R10
      idle(8);
      drive(1, 26'h500, 3, 10, 0, 0);  // R9 freed slot reused
      drive(0, '0, 0, 0, 1, 1);
      drive(0, '0, 0, 0, 1, 3);
      drive(0, '0, 0, 0, 1, 0);
      idle(10);
      // R9: every register full again once all lines are back
      for (int r = 0; r < 32; r++) begin
         sb_query_reg = RW'(r);
         #0.1;
         check("R9", "sb_query_empty after drain", sb_query_empty, 0);
      end
      @(negedge clk);

      for (int i = 0; i < 600; i++) begin
         bit rv; int rid;
         rv = 0; rid = $urandom % N;
         if (m_busy[rid] && !m_drain[rid] && ($urandom % 3 == 0)) rv = 1;
         drive(bit'($urandom % 2), LW'(26'h100 * (1 + $urandom % 6)),
               $urandom % W, 1 + $urandom % 15, rv, rid);
      end
      for (int k = 0; k < 12; k++) begin
         for (int e = 0; e < N; e++)
            if (m_busy[e] && !m_drain[e]) drive(0, '0, 0, 0, 1, e);
         idle(4);
      end
      idle(20);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule